// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers the interrupt status of a network controller into a single summary flag and an interrupt line. It holds four 16-bit registers: a main status register, a mask register for the main status sources, and two extended status registers. In each extended register, every status bit is paired with a control bit one position below it. Controller logic raises status bits through single-cycle event inputs. Software writes the registers through a simple write port with a register select and reads all four back in parallel. Some status bits are cleared by writing a one to them.

The summary flag is computed from the stored state and appears as bit 7 of the main read-back value. The interrupt line is the summary flag gated by a global interrupt-enable input. The first extended register also contains a software interrupt request bit. While the global enable is high, the block turns a pending request into a "request serviced" flag, and that flag then stays set until software clears it.

Top module: `isr_aggregator`

## Requirements
- R1: After reset all four read-back values are zero, and the summary flag and the interrupt line are low.
- R2: The summary flag (bit 7 of `rd_main`) is high in the same cycle whenever a main status bit among bits 8, 9, 10, 11, 12 and 14 is 1 and the mask bit at the same position is 0.
- R3: In the first extended register, status bits 1, 3, 5 and 9 are paired with mask bits 0, 2, 4 and 8 (the mask sits one bit below its status). A pair raises the summary when its status bit is 1 and its mask bit is 0.
- R4: In the second extended register, status bits 9 and 11 are paired with enable bits 8 and 10. A pair raises the summary when both its status bit and its enable bit are 1.
- R5: `irq_o` equals the summary flag AND `gie` in the same cycle. When no pair and no unmasked main source is active, the summary is 0 (R10).
- R6: If bit 7 of the first extended register is 1 at a clock edge while `gie` is high, the next state has bit 7 cleared and bit 6 set. This takes priority over a write or an event in that cycle. While `gie` is low, bit 7 is held.
- R7: Writing a 1 clears bits 1, 3, 5, 6 and 9 of the first extended register and bits 4, 7, 9 and 11 of the second. Writing a 0 to those bits leaves them unchanged.
- R8: `wr_sel` selects 0 = main, 1 = mask, 2 = extended 1, 3 = extended 2. Every other bit of the selected register takes the written value, except bit 7 of the main register, which ignores writes.
- R9: An event input bit sets the matching status bit, visible one cycle later. A set wins over a write or a clear in the same cycle. Events on main bit 7 are ignored.
- R10: A set status bit whose pair or mask disables it leaves the summary flag and `irq_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 16 | Write data |
| evt_main | input | 16 | Event pulses setting main status bits |
| evt_ext1 | input | 16 | Event pulses setting extended-1 bits |
| evt_ext2 | input | 16 | Event pulses setting extended-2 bits |
| rd_main | output | 16 | Main status read-back, bit 7 is the summary |
| rd_mask | output | 16 | Mask register read-back |
| rd_ext1 | output | 16 | Extended-1 read-back |
| rd_ext2 | output | 16 | Extended-2 read-back |
| summary | output | 1 | Summary flag |
| irq_o | output | 1 | Interrupt line |

## Verification
The summary flag is derived combinationally from the stored registers. A wrong pair polarity or a wrong mask position therefore shows on `summary` and `irq_o` in the same cycle the offending register value appears on the read-back ports. A corrupted write-clear, event priority or request hand-off shows on the read-back of the affected register one cycle after the write or event. The sweeps cover every status/mask combination of every pair, so any misplaced bit shows up within the first pass over that register.

// File: rtl/isr_agg_pkg.sv
package isr_agg_pkg;
   typedef enum logic [1:0] {
      SEL_MAIN = 2'd0,
      SEL_MASK = 2'd1,
      SEL_EXT1 = 2'd2,
      SEL_EXT2 = 2'd3
   } isr_sel_e;
endpackage

// File: rtl/isr_status_reg.sv
module isr_status_reg #(
   parameter int W = 16,
   parameter logic [W-1:0] W1C_MASK = '0,
   parameter logic [W-1:0] RO_MASK  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_hit,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] force_clr,
   input  logic [W-1:0] force_set,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] DIRECT = ~(W1C_MASK | RO_MASK);

   initial begin
      if ((W1C_MASK & RO_MASK) != '0)
         $error("isr_status_reg: a bit cannot be both write-clear and read-only");
   end

   logic [W-1:0] wr_val;
   logic [W-1:0] nxt;

   always_comb begin
      wr_val = q;
      if (wr_hit)
         wr_val = (wr_data & DIRECT) | (q & W1C_MASK & ~wr_data) | (q & RO_MASK);
      nxt = ((wr_val | (evt & ~RO_MASK)) & ~force_clr) | force_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/isr_pair_detect.sv
module isr_pair_detect #(
   parameter int W = 16,
   parameter logic [W-1:0] LOW_MASK = '0,
   parameter bit EN_ACTIVE_HIGH = 1'b0
) (
   input  logic [W-1:0] src,
   output logic         hit
);
   initial begin
      if (LOW_MASK[W-1])
         $error("isr_pair_detect: top bit has no partner above it");
   end

   logic [W-1:0] h;

   for (genvar k = 0; k < W - 1; k++) begin : g_pair
      if (!LOW_MASK[k]) begin : g_off
         assign h[k] = 1'b0;
      end else if (EN_ACTIVE_HIGH) begin : g_en
         assign h[k] = src[k+1] & src[k];
      end else begin : g_msk
         assign h[k] = src[k+1] & ~src[k];
      end
   end
   assign h[W-1] = 1'b0;

   assign hit = |h;
endmodule

// File: rtl/isr_aggregator.sv
module isr_aggregator #(
   parameter int W = 16,
   parameter int SUM_BIT = 7,
   parameter logic [W-1:0] MAIN_SRC = 16'h5F00,
   parameter logic [W-1:0] E1_LOW   = 16'h0115,
   parameter logic [W-1:0] E1_W1C   = 16'h026A,
   parameter int E1_REQ_BIT  = 7,
   parameter int E1_DONE_BIT = 6,
   parameter logic [W-1:0] E2_LOW   = 16'h0500,
   parameter logic [W-1:0] E2_W1C   = 16'h0A90
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         gie,
   input  logic         wr_en,
   input  logic [1:0]   wr_sel,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] evt_main,
   input  logic [W-1:0] evt_ext1,
   input  logic [W-1:0] evt_ext2,
   output logic [W-1:0] rd_main,
   output logic [W-1:0] rd_mask,
   output logic [W-1:0] rd_ext1,
   output logic [W-1:0] rd_ext2,
   output logic         summary,
   output logic         irq_o
);
   import isr_agg_pkg::*;

   localparam logic [W-1:0] SUM_1H  = W'(1) << SUM_BIT;
   localparam logic [W-1:0] REQ_1H  = W'(1) << E1_REQ_BIT;
   localparam logic [W-1:0] DONE_1H = W'(1) << E1_DONE_BIT;

   initial begin
      if (SUM_BIT >= W || E1_REQ_BIT >= W || E1_DONE_BIT >= W)
         $error("isr_aggregator: bit index outside register width");
      if ((MAIN_SRC & SUM_1H) != '0)
         $error("isr_aggregator: summary bit cannot be a source");
   end

   logic [W-1:0] main_q, mask_q, e1_q, e2_q;
   logic [W-1:0] e1_fclr, e1_fset;
   logic         ureq;
   logic         main_hit, e1_hit, e2_hit;

   assign ureq    = gie & e1_q[E1_REQ_BIT];
   assign e1_fclr = ureq ? REQ_1H  : '0;
   assign e1_fset = ureq ? DONE_1H : '0;

   isr_status_reg #(.W(W), .W1C_MASK('0), .RO_MASK(SUM_1H)) u_main (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_en && (isr_sel_e'(wr_sel) == SEL_MAIN)),
      .wr_data(wr_data), .evt(evt_main),
      .force_clr('0), .force_set('0), .q(main_q));

   isr_status_reg #(.W(W), .W1C_MASK('0), .RO_MASK('0)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_en && (isr_sel_e'(wr_sel) == SEL_MASK)),
      .wr_data(wr_data), .evt('0),
      .force_clr('0), .force_set('0), .q(mask_q));

   isr_status_reg #(.W(W), .W1C_MASK(E1_W1C), .RO_MASK('0)) u_ext1 (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_en && (isr_sel_e'(wr_sel) == SEL_EXT1)),
      .wr_data(wr_data), .evt(evt_ext1),
      .force_clr(e1_fclr), .force_set(e1_fset), .q(e1_q));

   isr_status_reg #(.W(W), .W1C_MASK(E2_W1C), .RO_MASK('0)) u_ext2 (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_en && (isr_sel_e'(wr_sel) == SEL_EXT2)),
      .wr_data(wr_data), .evt(evt_ext2),
      .force_clr('0), .force_set('0), .q(e2_q));

   isr_pair_detect #(.W(W), .LOW_MASK(E1_LOW), .EN_ACTIVE_HIGH(1'b0)) u_pd1 (
      .src(e1_q), .hit(e1_hit));

   isr_pair_detect #(.W(W), .LOW_MASK(E2_LOW), .EN_ACTIVE_HIGH(1'b1)) u_pd2 (
      .src(e2_q), .hit(e2_hit));

   assign main_hit = |(main_q & ~mask_q & MAIN_SRC);
   assign summary  = main_hit | e1_hit | e2_hit;
   assign irq_o    = summary & gie;

   assign rd_main = (main_q & ~SUM_1H) | (SUM_1H & {W{summary}});
   assign rd_mask = mask_q;
   assign rd_ext1 = e1_q;
   assign rd_ext2 = e2_q;
endmodule

// File: rtl/isr_agg_chk.sv
module isr_agg_chk #(
   parameter int W = 16,
   parameter int SUM_BIT = 7,
   parameter logic [W-1:0] MAIN_SRC = 16'h5F00,
   parameter logic [W-1:0] E1_LOW   = 16'h0115,
   parameter logic [W-1:0] E1_W1C   = 16'h026A,
   parameter int E1_REQ_BIT  = 7,
   parameter int E1_DONE_BIT = 6,
   parameter logic [W-1:0] E2_LOW   = 16'h0500
) (
   input logic         clk,
   input logic         rst_n,
   input logic         gie,
   input logic         wr_en,
   input logic [1:0]   wr_sel,
   input logic [W-1:0] wr_data,
   input logic [W-1:0] evt_ext1,
   input logic [W-1:0] evt_ext2,
   input logic [W-1:0] rd_main,
   input logic [W-1:0] rd_mask,
   input logic [W-1:0] rd_ext1,
   input logic [W-1:0] rd_ext2,
   input logic         summary,
   input logic         irq_o
);
   localparam logic [W-1:0] DONE_1H = W'(1) << E1_DONE_BIT;

   logic [W-1:0] e1_clr_exp;
   assign e1_clr_exp = (wr_en && wr_sel == 2'd2)
                     ? (wr_data & E1_W1C & ~evt_ext1 &
                        ~((gie && rd_ext1[E1_REQ_BIT]) ? DONE_1H : '0))
                     : '0;

   // R5
   p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (rd_main[SUM_BIT] && gie));

   // R2
   p_main_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_main & ~rd_mask & MAIN_SRC) != '0) |-> summary);

   // R3
   p_ext1_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((((rd_ext1 >> 1) & ~rd_ext1) & E1_LOW) != '0) |-> summary);

   // R4
   p_ext2_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((((rd_ext2 >> 1) & rd_ext2) & E2_LOW) != '0) |-> summary);

   // R6
   p_user_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (gie && rd_ext1[E1_REQ_BIT]) |=> (!rd_ext1[E1_REQ_BIT] && rd_ext1[E1_DONE_BIT]));

   // R7
   p_w1c_ext1_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (e1_clr_exp != '0) |=> ((rd_ext1 & $past(e1_clr_exp)) == '0));

   // R9
   p_evt_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_ext2 != '0) |=> ((rd_ext2 & $past(evt_ext2)) == $past(evt_ext2)));
endmodule

bind isr_aggregator isr_agg_chk #(
   .W(W), .SUM_BIT(SUM_BIT), .MAIN_SRC(MAIN_SRC), .E1_LOW(E1_LOW),
   .E1_W1C(E1_W1C), .E1_REQ_BIT(E1_REQ_BIT), .E1_DONE_BIT(E1_DONE_BIT),
   .E2_LOW(E2_LOW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .gie(gie), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .evt_ext1(evt_ext1), .evt_ext2(evt_ext2),
   .rd_main(rd_main), .rd_mask(rd_mask), .rd_ext1(rd_ext1), .rd_ext2(rd_ext2),
   .summary(summary), .irq_o(irq_o)
);

// File: tb/sim_isr_aggregator.sv
`timescale 1ns/1ps
module sim_isr_aggregator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        gie = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = '0;
   logic [15:0] evt_main = '0, evt_ext1 = '0, evt_ext2 = '0;
   logic [15:0] rd_main, rd_mask, rd_ext1, rd_ext2;
   logic        summary, irq_o;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   isr_aggregator u0 (
      .clk(clk), .rst_n(rst_n), .gie(gie), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .evt_main(evt_main), .evt_ext1(evt_ext1),
      .evt_ext2(evt_ext2), .rd_main(rd_main), .rd_mask(rd_mask),
      .rd_ext1(rd_ext1), .rd_ext2(rd_ext2), .summary(summary), .irq_o(irq_o));

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic step(input logic we, input logic [1:0] sel, input logic [15:0] d,
                       input logic [15:0] em, input logic [15:0] e1, input logic [15:0] e2);
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = d;
      evt_main = em; evt_ext1 = e1; evt_ext2 = e2;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      evt_main = '0; evt_ext1 = '0; evt_ext2 = '0;
   endtask

   // Expected-value helpers from the requirements
   function automatic logic [15:0] main_pos(input logic [5:0] x);
      return {1'b0, x[5], 1'b0, x[4:0], 8'h00};          // bits 8..12, 14
   endfunction
   function automatic logic [15:0] place4(input logic [3:0] x, input int off);
      // pairs at 0,2,4,8 (off=0) or 1,3,5,9 (off=1)
      logic [15:0] v = '0;
      v[0 + off] = x[0]; v[2 + off] = x[1]; v[4 + off] = x[2]; v[8 + off] = x[3];
      return v;
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 main", rd_main, 16'h0);
      chk("R1 mask", rd_mask, 16'h0);
      chk("R1 ext1", rd_ext1, 16'h0);
      chk("R1 ext2", rd_ext2, 16'h0);
      chk("R1 irq", {14'b0, summary, irq_o}, 16'h0);

      // R2 / R8 / R10: sweep all main sources against all masks
      gie = 1'b1;
      for (int s = 0; s < 64; s++) begin
         for (int m = 0; m < 64; m++) begin
            logic [15:0] mv, dv;
            logic        hit;
            mv  = main_pos(6'(m)) | 16'h00F0;
            dv  = main_pos(6'(s)) | 16'h0080 | 16'(s & 15);
            hit = |(6'(s) & ~6'(m));
            step(1'b1, 2'd1, mv, '0, '0, '0);
            step(1'b1, 2'd0, dv, '0, '0, '0);
            chk("R2 R8 main readback", rd_main, (dv & 16'hFF7F) | (hit ? 16'h0080 : 16'h0));
            chk("R5 R10 irq", {14'b0, summary, irq_o}, {14'b0, hit, hit});
         end
      end
      step(1'b1, 2'd0, 16'h0, '0, '0, '0);
      step(1'b1, 2'd1, 16'h0, '0, '0, '0);

      // R3 / R7: every status/mask combination of extended-1 pairs
      for (int s = 0; s < 16; s++) begin
         for (int m = 0; m < 16; m++) begin
            logic [15:0] mv, sv;
            logic        hit;
            mv  = place4(4'(m), 0);
            sv  = place4(4'(s), 1);
            hit = |(4'(s) & ~4'(m));
            step(1'b1, 2'd2, mv | 16'h026A, '0, '0, '0);
            chk("R7 R8 ext1 cleared", rd_ext1, mv);
            step(1'b0, 2'd0, 16'h0, '0, sv, '0);
            chk("R3 R9 ext1 set", rd_ext1, mv | sv);
            chk("R3 R5 summary", {14'b0, summary, irq_o}, {14'b0, hit, hit});
         end
      end
      step(1'b1, 2'd2, 16'h026A, '0, '0, '0);

      // R4 / R7: extended-2 pairs plus non-source clear bits 4 and 7
      for (int c = 0; c < 64; c++) begin
         logic [15:0] ev, sv;
         logic        hit;
         ev = '0; sv = '0;
         ev[8] = c[0]; ev[10] = c[1];
         sv[9] = c[2]; sv[11] = c[3]; sv[4] = c[4]; sv[7] = c[5];
         hit = (c[0] & c[2]) | (c[1] & c[3]);
         step(1'b1, 2'd3, ev | 16'h0A90, '0, '0, '0);
         chk("R7 ext2 cleared", rd_ext2, ev);
         step(1'b0, 2'd0, 16'h0, '0, '0, sv);
         chk("R4 R9 ext2 set", rd_ext2, ev | sv);
         chk("R4 summary", {15'b0, summary}, {15'b0, hit});
      end
      step(1'b1, 2'd3, 16'h0A90, '0, '0, '0);

      // R5: gate low keeps line low with active source
      step(1'b0, 2'd0, 16'h0, '0, '0, 16'h0300);
      gie = 1'b0;
      #1;
      chk("R5 gate low", {14'b0, summary, irq_o}, 16'h0002);
      gie = 1'b1;
      #1;
      chk("R5 gate high", {14'b0, summary, irq_o}, 16'h0003);
      step(1'b1, 2'd3, 16'h0A90, '0, '0, '0);
      chk("R4 ext2 cleared pair", {15'b0, summary}, 16'h0);

      // R6: request held while gate low, serviced when high
      gie = 1'b0;
      step(1'b1, 2'd2, 16'h0080, '0, '0, '0);
      chk("R6 req held", rd_ext1, 16'h0080);
      step(1'b0, 2'd0, 16'h0, '0, '0, '0);
      chk("R6 req still held", rd_ext1, 16'h0080);
      chk("R10 req not a source", {14'b0, summary, irq_o}, 16'h0);
      gie = 1'b1;
      @(negedge clk);
      chk("R6 req serviced", rd_ext1, 16'h0040);
      step(1'b1, 2'd2, 16'h0000, '0, '0, '0);
      chk("R6 R7 done kept on zero write", rd_ext1, 16'h0040);
      step(1'b1, 2'd2, 16'h0040, '0, '0, '0);
      chk("R7 done cleared", rd_ext1, 16'h0000);

      // R7: zero write keeps a status bit
      step(1'b0, 2'd0, 16'h0, '0, 16'h0002, '0);
      step(1'b1, 2'd2, 16'h0000, '0, '0, '0);
      chk("R7 zero write keeps", rd_ext1, 16'h0002);
      step(1'b1, 2'd2, 16'h0002, '0, '0, '0);
      chk("R7 one write clears", rd_ext1, 16'h0000);

      // R9: event wins over simultaneous clear
      step(1'b1, 2'd2, 16'h0008, '0, 16'h0008, '0);
      chk("R9 set beats clear", rd_ext1, 16'h0008);
      step(1'b1, 2'd2, 16'h0008, '0, '0, '0);
      // R9: event on main bit 7 ignored
      step(1'b0, 2'd0, 16'h0, 16'h0080, '0, '0);
      chk("R9 main bit7 event ignored", rd_main, 16'h0000);
      // R10: masked main source
      step(1'b1, 2'd1, 16'h0100, '0, '0, '0);
      step(1'b0, 2'd0, 16'h0, 16'h0100, '0, '0);
      chk("R10 masked source", rd_main, 16'h0100);
      chk("R10 masked irq", {14'b0, summary, irq_o}, 16'h0);

      // R8: direct bits of mask and extended-2
      step(1'b1, 2'd1, 16'hA5C3, '0, '0, '0);
      chk("R8 mask readback", rd_mask, 16'hA5C3);
      step(1'b1, 2'd3, 16'h5555, '0, '0, '0);
      chk("R8 ext2 direct bits", rd_ext2, 16'h5545);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule